// File: doc/BRIEF.md
# Dual-Source Harvester Converter Scheduler

This block arbitrates a single shared-inductor DC-DC converter between two energy harvesting sources: a thermoelectric array (the primary source) and a piezo element (the secondary source). Comparator flags report whether each source has enough power. The thermoelectric source wins whenever its flag is high. The piezo source is served alone when the primary source is weak. When the primary source is active, the piezo source is fitted into the idle part of each primary switching period: the low half of the primary clock, and only once the primary inductor current has been reported as back at zero. If neither flag is high, neither source is selected.

Both switching clocks are divided down from one fast system clock. The primary clock has a 50% duty cycle and one of two rates, chosen by a flag that says whether the array is wired in series (faster) or in parallel (slower). A new rate takes effect only at the start of a period. The piezo clock runs at a fixed higher rate. A load comparator flag, high while the storage capacitor is still below its full level, gates both clock outputs. All comparator and zero-current inputs are asynchronous and pass through two-flop synchronisers.

Top module: `hybrid_src_sel`

## Requirements
- R1: `teg_mode_o` equals the value that `teg_pwr_ok_i` had three clock cycles earlier. The thermoelectric source is selected whenever its flag is high, regardless of the piezo flag.
- R2: While the thermoelectric flag (three cycles earlier) is low, `pz_mode_o` equals the value that `pz_pwr_ok_i` had three cycles earlier.
- R3: When both power flags were low three cycles earlier, both mode outputs and both clock outputs are low.
- R4: `pz_mode_o` is never high while `teg_clk_o` is high. The piezo source never overlaps the charge half of the primary period.
- R5: With the thermoelectric mode active, piezo mode is granted only during the low half of the primary clock. The grant needs the synchronised zero-current flag, or a grant already held in the same low half. It needs the piezo power flag. It is removed in the cycle where the primary clock rises. A zero-current pulse that lies wholly within the high half has no effect. A grant shows three cycles after the zero-current flag rises. A grant ends three cycles after the piezo power flag falls.
- R6: `teg_clk_o` has a 50% duty cycle. Each half lasts SYS_CLK_HZ/(2*TEG_SER_HZ) cycles (21 by default) when `array_series_i` is 1. Each half lasts SYS_CLK_HZ/(2*TEG_PAR_HZ) cycles (200 by default) when `array_series_i` is 0.
- R7: A change of `array_series_i` takes effect only at a rising edge of the primary clock. Every primary period has a high half and a low half of equal length.
- R8: `pz_clk_o` runs with halves of SYS_CLK_HZ/(2*PZ_HZ) cycles (4 by default) while piezo mode is held. It is low whenever `pz_mode_o` is low.
- R9: When `load_below_full_i` has been low for the previous two cycles, `teg_clk_o` is low. When it has been low for the previous three cycles, `pz_clk_o` is low. The mode outputs are not affected by this input.
- R10: During reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| teg_pwr_ok_i | input | 1 | Thermoelectric voltage above power threshold (async) |
| pz_pwr_ok_i | input | 1 | Piezo source has usable power (async) |
| teg_zc_i | input | 1 | Thermoelectric inductor current at zero (async) |
| array_series_i | input | 1 | 1: array wired in series, 0: in parallel (async) |
| load_below_full_i | input | 1 | 1: load capacitor below full, keep running (async) |
| teg_mode_o | output | 1 | Thermoelectric source selected |
| pz_mode_o | output | 1 | Piezo source selected |
| teg_clk_o | output | 1 | Gated thermoelectric switching clock |
| pz_clk_o | output | 1 | Gated piezo switching clock |

## Verification
Each input reaches the mode outputs three cycles after it changes: two cycles in the synchroniser and one in the mode register. The load flag stops the primary clock after two cycles and the piezo clock after three, because the piezo clock leaves through its own output flop. The bench drives inputs just after each falling edge and samples there first. It holds a short history of what it drove, so each sample is compared with the input value from exactly three (or two) cycles before. Clock periods and dead-time grant windows are counted in whole samples from the first sample after a transition of `teg_clk_o`. The expected counts follow from the same three-cycle delay.

// File: rtl/hss_pkg.sv
package hss_pkg;

   function automatic int unsigned half_count(input int unsigned sys_hz,
                                              input int unsigned out_hz);
      return sys_hz / (2 * out_hz);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   typedef struct packed {
      logic teg_ok;
      logic pz_ok;
      logic zc;
      logic series;
      logic run;
   } hss_in_t;

   localparam int unsigned HSS_IN_W = $bits(hss_in_t);

endpackage

// File: rtl/hss_sync2.sv
module hss_sync2 #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("hss_sync2: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
         end else begin
            meta_q <= d_i[b];
            stab_q <= meta_q;
         end
      end
      assign q_o[b] = stab_q;
   end

endmodule

// File: rtl/hss_clk_div.sv
module hss_clk_div #(
   parameter int unsigned HALF_A = 4,
   parameter int unsigned HALF_B = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_a_i,
   output logic ph_o,
   output logic ph_nxt_o
);

   localparam int unsigned HMAX = hss_pkg::max2(HALF_A, HALF_B);
   localparam int unsigned CW   = $clog2(HMAX + 1);

   if (HALF_A < 1 || HALF_B < 1) begin : g_bad_half
      $error("hss_clk_div: half periods must be at least one cycle");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] half_q;
   logic          ph_q;
   logic          wrap;

   assign wrap     = (cnt_q == half_q - CW'(1));
   assign ph_nxt_o = ph_q ^ wrap;
   assign ph_o     = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ph_q   <= 1'b1;
         half_q <= CW'(HALF_A);
      end else if (wrap) begin
         cnt_q <= '0;
         ph_q  <= ~ph_q;
         if (!ph_q) begin
            half_q <= sel_a_i ? CW'(HALF_A) : CW'(HALF_B);
         end
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/hss_mode.sv
module hss_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic teg_ok_i,
   input  logic pz_ok_i,
   input  logic zc_i,
   input  logic teg_ph_nxt_i,
   output logic teg_mode_o,
   output logic pz_mode_o,
   output logic pz_nxt_o
);

   logic teg_q;
   logic pz_q;

   always_comb begin
      if (teg_ok_i) begin
         pz_nxt_o = pz_ok_i && !teg_ph_nxt_i && (zc_i || (pz_q && teg_q));
      end else begin
         pz_nxt_o = pz_ok_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         teg_q <= 1'b0;
         pz_q  <= 1'b0;
      end else begin
         teg_q <= teg_ok_i;
         pz_q  <= pz_nxt_o;
      end
   end

   assign teg_mode_o = teg_q;
   assign pz_mode_o  = pz_q;

endmodule

// File: rtl/hybrid_src_sel.sv
module hybrid_src_sel #(
   parameter int unsigned SYS_CLK_HZ = 1_600_000,
   parameter int unsigned TEG_SER_HZ = 38_000,
   parameter int unsigned TEG_PAR_HZ = 4_000,
   parameter int unsigned PZ_HZ      = 200_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic teg_pwr_ok_i,
   input  logic pz_pwr_ok_i,
   input  logic teg_zc_i,
   input  logic array_series_i,
   input  logic load_below_full_i,
   output logic teg_mode_o,
   output logic pz_mode_o,
   output logic teg_clk_o,
   output logic pz_clk_o
);

   import hss_pkg::*;

   localparam int unsigned SER_HALF = half_count(SYS_CLK_HZ, TEG_SER_HZ);
   localparam int unsigned PAR_HALF = half_count(SYS_CLK_HZ, TEG_PAR_HZ);
   localparam int unsigned PZ_HALF  = half_count(SYS_CLK_HZ, PZ_HZ);

   if (SER_HALF < 1 || PAR_HALF < 1 || PZ_HALF < 1) begin : g_bad_rate
      $error("hybrid_src_sel: system clock too slow for a requested rate");
   end
   if (PZ_HALF >= SER_HALF) begin : g_bad_order
      $error("hybrid_src_sel: piezo clock must be faster than primary clock");
   end

   hss_in_t raw_in;
   hss_in_t syn_in;

   assign raw_in = '{teg_ok: teg_pwr_ok_i, pz_ok: pz_pwr_ok_i, zc: teg_zc_i,
                     series: array_series_i, run: load_below_full_i};

   logic [HSS_IN_W-1:0] syn_vec;

   hss_sync2 #(.W(HSS_IN_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_vec)
   );

   assign syn_in = hss_in_t'(syn_vec);

   logic run_s;
   assign run_s = syn_in.run;

   logic teg_ph;
   logic teg_ph_nxt;
   logic pz_ph;
   logic pz_ph_nxt;

   hss_clk_div #(.HALF_A(SER_HALF), .HALF_B(PAR_HALF)) u_teg_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_a_i  (syn_in.series),
      .ph_o     (teg_ph),
      .ph_nxt_o (teg_ph_nxt)
   );

   hss_clk_div #(.HALF_A(PZ_HALF), .HALF_B(PZ_HALF)) u_pz_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_a_i  (1'b1),
      .ph_o     (pz_ph),
      .ph_nxt_o (pz_ph_nxt)
   );

   logic pz_nxt;

   hss_mode u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .teg_ok_i     (syn_in.teg_ok),
      .pz_ok_i      (syn_in.pz_ok),
      .zc_i         (syn_in.zc),
      .teg_ph_nxt_i (teg_ph_nxt),
      .teg_mode_o   (teg_mode_o),
      .pz_mode_o    (pz_mode_o),
      .pz_nxt_o     (pz_nxt)
   );

   logic pz_clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pz_clk_q <= 1'b0;
      end else begin
         pz_clk_q <= pz_ph_nxt && pz_nxt && run_s;
      end
   end

   assign teg_clk_o = teg_ph && teg_mode_o && run_s;
   assign pz_clk_o  = pz_clk_q;

   logic unused_pz_ph;
   assign unused_pz_ph = pz_ph;

endmodule

// File: rtl/hss_src_sel_chk.sv
module hss_src_sel_chk #(
   parameter int unsigned SER_HALF = 21,
   parameter int unsigned PAR_HALF = 200
) (
   input logic clk,
   input logic rst_n,
   input logic teg_pwr_ok_i,
   input logic pz_pwr_ok_i,
   input logic load_below_full_i,
   input logic teg_ph,
   input logic unused_pz_ph,
   input logic teg_mode_o,
   input logic pz_mode_o,
   input logic teg_clk_o,
   input logic pz_clk_o
);

   int unsigned age_q;
   int unsigned seg_q;
   int unsigned hi_q;
   logic        ph_d;
   logic        toggled;
   logic        warm;

   assign toggled = (teg_ph != ph_d);
   assign warm    = (age_q >= 4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= 0;
         seg_q <= 0;
         hi_q  <= 0;
         ph_d  <= 1'b1;
      end else begin
         if (age_q < 8) age_q <= age_q + 1;
         ph_d  <= teg_ph;
         seg_q <= toggled ? 1 : seg_q + 1;
         if (toggled && !teg_ph) hi_q <= seg_q;
      end
   end

   AST_TEG_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (teg_mode_o == $past(teg_pwr_ok_i, 3))); // R1

   AST_PZ_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(teg_pwr_ok_i, 3)) |-> (pz_mode_o == $past(pz_pwr_ok_i, 3))); // R2

   AST_NEITHER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(teg_pwr_ok_i, 3) && !$past(pz_pwr_ok_i, 3))
      |-> (!teg_clk_o && !pz_clk_o)); // R3

   AST_PZ_NOT_IN_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pz_mode_o && teg_mode_o) |-> !teg_ph); // R4

   AST_PZ_DROP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(teg_ph) && teg_mode_o) |-> !pz_mode_o); // R5

   AST_HALF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      toggled |-> (seg_q == SER_HALF || seg_q == PAR_HALF)); // R6

   AST_HALVES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (toggled && teg_ph) |-> (seg_q == hi_q)); // R7

   AST_PZ_CLK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      pz_clk_o |-> pz_mode_o); // R8

   AST_LOAD_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(load_below_full_i, 2) && !$past(load_below_full_i, 3))
      |-> (!teg_clk_o && !pz_clk_o)); // R9

   logic unused_chk;
   assign unused_chk = unused_pz_ph;

endmodule

bind hybrid_src_sel hss_src_sel_chk #(
   .SER_HALF (SER_HALF),
   .PAR_HALF (PAR_HALF)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .teg_pwr_ok_i      (teg_pwr_ok_i),
   .pz_pwr_ok_i       (pz_pwr_ok_i),
   .load_below_full_i (load_below_full_i),
   .teg_ph            (teg_ph),
   .unused_pz_ph      (unused_pz_ph),
   .teg_mode_o        (teg_mode_o),
   .pz_mode_o         (pz_mode_o),
   .teg_clk_o         (teg_clk_o),
   .pz_clk_o          (pz_clk_o)
);

// File: tb/tb_hybrid_src_sel.sv
module tb_hybrid_src_sel;

   localparam int SYS  = 1_600_000;
   localparam int FSER = 38_000;
   localparam int FPAR = 4_000;
   localparam int FPZ  = 200_000;

   function automatic int exp_half(input int f);
      return SYS / (2 * f);
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic teg_ok = 1'b0, pz_ok = 1'b0, zc = 1'b0, ser = 1'b1, run = 1'b1;
   logic teg_mode_o, pz_mode_o, teg_clk_o, pz_clk_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   hybrid_src_sel #(.SYS_CLK_HZ(SYS), .TEG_SER_HZ(FSER), .TEG_PAR_HZ(FPAR), .PZ_HZ(FPZ)) dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .teg_pwr_ok_i      (teg_ok),
      .pz_pwr_ok_i       (pz_ok),
      .teg_zc_i          (zc),
      .array_series_i    (ser),
      .load_below_full_i (run),
      .teg_mode_o        (teg_mode_o),
      .pz_mode_o         (pz_mode_o),
      .teg_clk_o         (teg_clk_o),
      .pz_clk_o          (pz_clk_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic sig(input int w);
      return (w == 0) ? teg_clk_o : pz_clk_o;
   endfunction

   task automatic meas(input int w, output int hi, output int lo);
      while (sig(w) !== 1'b0) @(negedge clk);
      while (sig(w) !== 1'b1) @(negedge clk);
      hi = 0;
      while (sig(w) === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (sig(w) === 1'b0) begin lo++; @(negedge clk); end
   endtask

   task automatic wait_fall();
      while (teg_clk_o !== 1'b1) @(negedge clk);
      while (teg_clk_o !== 1'b0) @(negedge clk);
   endtask

   task automatic wait_rise();
      while (teg_clk_o !== 1'b0) @(negedge clk);
      while (teg_clk_o !== 1'b1) @(negedge clk);
   endtask

   initial begin
      #(20 * 150_000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int hi, lo, cnt, cnt2;
      int hs, hp, hz;
      logic [4:0] h [0:2];
      void'($urandom(32'h5EED_0042));
      hs = exp_half(FSER);
      hp = exp_half(FPAR);
      hz = exp_half(FPZ);

      // R10 reset state
      repeat (5) @(negedge clk);
      check({teg_mode_o, pz_mode_o, teg_clk_o, pz_clk_o} == 4'b0, "R10 reset outputs",
            {teg_mode_o, pz_mode_o, teg_clk_o, pz_clk_o}, 0);
      rst_n = 1'b1;

      // R3 neither source
      repeat (10) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 60; i++) begin
         cnt += teg_mode_o + pz_mode_o + teg_clk_o + pz_clk_o;
         @(negedge clk);
      end
      check(cnt == 0, "R3 no source selected", cnt, 0);

      // R1 latency of primary selection
      teg_ok = 1'b1;
      @(negedge clk); @(negedge clk);
      check(teg_mode_o == 1'b0, "R1 mode not yet after 2 cycles", teg_mode_o, 0);
      @(negedge clk);
      check(teg_mode_o == 1'b1, "R1 mode after 3 cycles", teg_mode_o, 1);

      // R6 series rate
      meas(0, hi, lo);
      check(hi == hs, "R6 series high half", hi, hs);
      check(lo == hs, "R6 series low half", lo, hs);

      // R4 R5 full dead-time grant with zero-current held
      pz_ok = 1'b1; zc = 1'b1;
      wait_fall(); wait_fall();
      cnt = 0;
      for (int i = 0; i < hs; i++) begin cnt += pz_mode_o; @(negedge clk); end
      cnt2 = 0;
      for (int i = 0; i < hs; i++) begin cnt2 += pz_mode_o; @(negedge clk); end
      check(cnt == hs, "R5 piezo fills whole low half", cnt, hs);
      check(cnt2 == 0, "R4 piezo absent in high half", cnt2, 0);
      check(teg_mode_o == 1'b1, "R1 primary priority kept", teg_mode_o, 1);

      // R5 late zero-current flag
      zc = 1'b0;
      wait_fall(); wait_fall();
      cnt = 0;
      for (int i = 0; i < hs; i++) begin
         cnt += pz_mode_o;
         if (i == 5) zc = 1'b1;
         @(negedge clk);
      end
      check(cnt == hs - 8, "R5 grant three cycles after zero-current", cnt, hs - 8);

      // R5 zero-current only inside high half is ignored
      zc = 1'b0;
      wait_fall(); wait_fall();
      wait_rise();
      for (int i = 0; i < hs; i++) begin
         if (i == 0) zc = 1'b1;
         if (i == 10) zc = 1'b0;
         @(negedge clk);
      end
      cnt = 0;
      for (int i = 0; i < hs; i++) begin cnt += pz_mode_o; @(negedge clk); end
      check(cnt == 0, "R5 high-half zero-current ignored", cnt, 0);

      // R5 piezo power loss ends grant
      zc = 1'b1;
      wait_fall(); wait_fall();
      cnt = 0;
      for (int i = 0; i < hs; i++) begin
         cnt += pz_mode_o;
         if (i == 5) pz_ok = 1'b0;
         @(negedge clk);
      end
      check(cnt == 8, "R5 grant ends after piezo power drop", cnt, 8);

      // R7 R6 series to parallel and back
      pz_ok = 1'b0; zc = 1'b0;
      repeat ($urandom_range(1, 40)) @(negedge clk);
      ser = 1'b0;
      meas(0, hi, lo);
      check(hi == lo, "R7 period straddling switch", hi, lo);
      meas(0, hi, lo);
      check(hi == lo, "R7 next period even", hi, lo);
      meas(0, hi, lo);
      check(hi == hp && lo == hp, "R6 parallel half", hi, hp);
      repeat ($urandom_range(1, 300)) @(negedge clk);
      ser = 1'b1;
      meas(0, hi, lo);
      check(hi == lo, "R7 period straddling switch back", hi, lo);
      meas(0, hi, lo);
      check(hi == lo, "R7 next period even after back", hi, lo);
      meas(0, hi, lo);
      check(hi == hs && lo == hs, "R6 series half restored", hi, hs);

      // R2 R8 piezo alone
      teg_ok = 1'b0; pz_ok = 1'b1;
      repeat (6) @(negedge clk);
      check(teg_mode_o == 1'b0 && pz_mode_o == 1'b1, "R2 piezo alone selected",
            {teg_mode_o, pz_mode_o}, 1);
      meas(1, hi, lo);
      check(hi == hz && lo == hz, "R8 piezo half period", hi, hz);

      // R9 load full stops clocks, modes stay
      run = 1'b0;
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 100; i++) begin cnt += teg_clk_o + pz_clk_o; @(negedge clk); end
      check(cnt == 0, "R9 clocks stopped", cnt, 0);
      check(pz_mode_o == 1'b1, "R9 mode kept while stopped", pz_mode_o, 1);
      run = 1'b1;
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 20; i++) begin cnt += pz_clk_o; @(negedge clk); end
      check(cnt == 2 * hz, "R9 piezo clock resumes", cnt, 2 * hz);

      // random phase: R1 R2 R3 R4 R9 against delayed inputs
      for (int j = 0; j < 3; j++) h[j] = {teg_ok, pz_ok, zc, ser, run};
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         check(teg_mode_o == h[2][4], "R1 random primary mode", teg_mode_o, h[2][4]);
         if (!h[2][4])
            check(pz_mode_o == h[2][3], "R2 random piezo alone", pz_mode_o, h[2][3]);
         if (!h[2][4] && !h[2][3])
            check(!teg_clk_o && !pz_clk_o, "R3 random idle clocks", teg_clk_o + pz_clk_o, 0);
         check(!(pz_mode_o && teg_clk_o), "R4 random no overlap", pz_mode_o + teg_clk_o, 1);
         if (!h[1][0] && !h[2][0])
            check(!teg_clk_o && !pz_clk_o, "R9 random stop", teg_clk_o + pz_clk_o, 0);
         if ($urandom_range(0, 40) == 0) teg_ok = ~teg_ok;
         if ($urandom_range(0, 30) == 0) pz_ok = ~pz_ok;
         if ($urandom_range(0, 6) == 0)  zc = ~zc;
         if ($urandom_range(0, 500) == 0) ser = ~ser;
         if ($urandom_range(0, 50) == 0) run = ~run;
         h[2] = h[1];
         h[1] = h[0];
         h[0] = {teg_ok, pz_ok, zc, ser, run};
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule